// File: doc/BRIEF.md
# Serial Receiver with Per-Character Status

This block takes an asynchronous serial line and rebuilds characters from it. The line is sampled on an enable tick that runs at sixteen times the bit rate. Each frame has one start bit and then seven or eight data bits, least significant first. An optional even or odd parity bit follows, and the frame ends with one stop bit. For each character the block records three error flags: stop bit low, all-zero break, and parity mismatch. It stores the character and its flags as a single entry in a small receive queue, so the flags stay with the character they describe.

A host reads the oldest entry as one word that holds the flags and the data. A ready output tells the host that an entry is waiting. A one-cycle read strobe removes the entry. If a character finishes while the queue is full, the block drops it and sets a sticky overrun output.

Top module: `serial_rx_status`

## Requirements
- R1: After reset the queue is empty, `ready_o` is 0 and `overrun_o` is 0.
- R2: The line is sampled once per `tick_i`, 16 ticks per bit. A low level seen in idle is checked again 8 ticks later. If the line is high at that point, the event is discarded and no entry is created.
- R3: A frame is a low start bit, then the data bits LSB first, then a parity bit when `par_en_i`=1, then one stop bit. There are 8 data bits when `mode8_i`=1 and 7 when it is 0. One entry is written per frame, after the stop bit is sampled.
- R4: In 7-bit mode, bit 7 of the stored data is 0. In 8-bit mode, all eight bits come from the line.
- R5: When `par_odd_i`=0, parity is even: the data ones plus the parity bit must give an even count. When `par_odd_i`=1, parity is odd. A mismatch sets bit 8. While parity is disabled, bit 8 is always 0.
- R6: A stop bit sampled low sets bit 10 (framing error).
- R7: A character whose data bits are all 0 and whose stop bit is 0 sets bit 9 (break). Bit 10 is then also set.
- R8: A break received with odd parity enabled also has bit 8 set.
- R9: `rd_data_o` presents the oldest entry with bit 10 framing error, bit 9 break, bit 8 parity error and bits 7..0 data. `ready_o` is 1 exactly while the queue holds an entry. The word has no meaning while `ready_o` is 0.
- R10: A one-cycle `rd_i` pulse removes the oldest entry. A pulse while the queue is empty has no effect.
- R11: The queue holds 8 entries and returns them in arrival order, each with its own flags.
- R12: A character that completes while the queue holds 8 entries is dropped, even if a read happens in the same cycle. It sets `overrun_o`, which stays 1 until reset.
- R13: After a stop bit sampled low, no new start is recognised until the line has been seen high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Sample enable, 16 per bit time |
| rx_i | input | 1 | Serial line, idle high |
| mode8_i | input | 1 | 1: 8 data bits, 0: 7 data bits |
| par_en_i | input | 1 | Parity bit present and checked |
| par_odd_i | input | 1 | 1: odd parity, 0: even parity |
| rd_i | input | 1 | Read strobe, removes the oldest entry |
| rd_data_o | output | 11 | Oldest entry: flags in bits 10..8, data in bits 7..0 |
| ready_o | output | 1 | At least one entry waiting |
| overrun_o | output | 1 | Sticky: a character was dropped on a full queue |

## Verification
The bench sends an all-zero frame with its stop bit low, with and without odd parity. A design that derived break from data bits alone, or that skipped the forced parity flag, would report the wrong flag combination. It holds the line low for several bit times after a break; a receiver that re-armed at once would queue a second phantom character. It sends short low glitches, which a design without mid-start confirmation would turn into characters. It fills the queue past its depth, where a wrong full check would either overwrite an entry or fail to raise the sticky overrun. It sends 7-bit frames with a set top bit, where an unmasked shift register would leak a stale bit into bit 7.

// File: rtl/serial_rx_pkg.sv
package serial_rx_pkg;
  localparam int ENTRY_W = 11;

  typedef struct packed {
    logic       frm_err;
    logic       brk;
    logic       par_err;
    logic [7:0] data;
  } rx_entry_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_BITS,
    ST_WAIT_HI
  } rx_state_e;
endpackage

// File: rtl/serial_rx_sampler.sv
module serial_rx_sampler import serial_rx_pkg::*; #(
  parameter int OSR = 16
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       tick_i,
  input  logic       rx_i,
  input  logic       mode8_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  output logic       done_o,
  output logic [7:0] shift_o,
  output logic       pbit_o,
  output logic       stop_o,
  output logic       mode8_o,
  output logic       par_en_o,
  output logic       par_odd_o
);
  localparam int CW = $clog2(OSR);
  localparam logic [CW-1:0] MID  = CW'(OSR/2 - 1);
  localparam logic [CW-1:0] LAST = CW'(OSR - 1);

  rx_state_e     state_q;
  logic [CW-1:0] cnt_q;
  logic [3:0]    slot_q;
  logic [3:0]    ndata, stop_slot;

  always_comb begin
    ndata     = mode8_o ? 4'd8 : 4'd7;
    stop_slot = ndata + {3'b000, par_en_o};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      slot_q    <= '0;
      done_o    <= 1'b0;
      shift_o   <= '0;
      pbit_o    <= 1'b0;
      stop_o    <= 1'b1;
      mode8_o   <= 1'b1;
      par_en_o  <= 1'b0;
      par_odd_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_q)
        ST_IDLE: if (tick_i && !rx_i) begin
          state_q   <= ST_START;
          cnt_q     <= '0;
          slot_q    <= '0;
          shift_o   <= '0;
          mode8_o   <= mode8_i;
          par_en_o  <= par_en_i;
          par_odd_o <= par_odd_i;
        end
        ST_START: if (tick_i) begin
          if (cnt_q == MID) begin
            cnt_q   <= '0;
            state_q <= rx_i ? ST_IDLE : ST_BITS;
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_BITS: if (tick_i) begin
          if (cnt_q == LAST) begin
            cnt_q  <= '0;
            slot_q <= slot_q + 1'b1;
            if (slot_q < ndata) begin
              shift_o <= {rx_i, shift_o[7:1]};
            end else if (slot_q == stop_slot) begin
              stop_o  <= rx_i;
              done_o  <= 1'b1;
              state_q <= rx_i ? ST_IDLE : ST_WAIT_HI;
            end else begin
              pbit_o <= rx_i;
            end
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        ST_WAIT_HI: if (rx_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/serial_rx_classify.sv
module serial_rx_classify import serial_rx_pkg::*; (
  input  logic [7:0] shift_i,
  input  logic       mode8_i,
  input  logic       par_en_i,
  input  logic       par_odd_i,
  input  logic       pbit_i,
  input  logic       stop_i,
  output rx_entry_t  ent_o
);
  logic [7:0] data;
  logic       brk, ones_odd;

  always_comb begin
    // 7-bit frames leave the data in the upper seven bits of the shifter
    data     = mode8_i ? shift_i : {1'b0, shift_i[7:1]};
    brk      = !stop_i && (data == 8'h00);
    ones_odd = (^data) ^ pbit_i;
    ent_o.data    = data;
    ent_o.brk     = brk;
    ent_o.frm_err = !stop_i;
    ent_o.par_err = par_en_i && ((ones_odd ^ par_odd_i) || (brk && par_odd_i));
  end
endmodule

// File: rtl/serial_rx_fifo.sv
module serial_rx_fifo #(
  parameter int W     = 11,
  parameter int DEPTH = 8
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     push_i,
  input  logic [W-1:0]             din_i,
  input  logic                     pop_i,
  output logic [W-1:0]             dout_o,
  output logic                     empty_o,
  output logic                     full_o,
  output logic [$clog2(DEPTH):0]   cnt_o
);
  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;

  logic [W-1:0]  mem_q [DEPTH];
  logic [AW-1:0] wp_q, rp_q;

  assign empty_o = (cnt_o == '0);
  assign full_o  = (cnt_o == CW'(DEPTH));
  assign dout_o  = mem_q[rp_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_o <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else begin
      if (push_i) begin
        mem_q[wp_q] <= din_i;
        wp_q        <= wp_q + 1'b1;
      end
      if (pop_i) rp_q <= rp_q + 1'b1;
      cnt_o <= cnt_o + CW'(push_i) - CW'(pop_i);
    end
  end
endmodule

// File: rtl/serial_rx_status.sv
module serial_rx_status import serial_rx_pkg::*; #(
  parameter int OSR        = 16,
  parameter int FIFO_DEPTH = 8
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               tick_i,
  input  logic               rx_i,
  input  logic               mode8_i,
  input  logic               par_en_i,
  input  logic               par_odd_i,
  input  logic               rd_i,
  output logic [ENTRY_W-1:0] rd_data_o,
  output logic               ready_o,
  output logic               overrun_o
);
  localparam int CW = $clog2(FIFO_DEPTH) + 1;

  logic [1:0]    sync_q;
  logic          frame_done, pbit, stop_b, mode8_l, par_en_l, par_odd_l;
  logic [7:0]    shift;
  rx_entry_t     ent;
  logic          fifo_empty, fifo_full, push, pop;
  logic [CW-1:0] fifo_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= 2'b11;
    else         sync_q <= {sync_q[0], rx_i};
  end

  serial_rx_sampler #(.OSR(OSR)) u_sampler (
    .clk_i, .rst_ni, .tick_i,
    .rx_i      (sync_q[1]),
    .mode8_i, .par_en_i, .par_odd_i,
    .done_o    (frame_done),
    .shift_o   (shift),
    .pbit_o    (pbit),
    .stop_o    (stop_b),
    .mode8_o   (mode8_l),
    .par_en_o  (par_en_l),
    .par_odd_o (par_odd_l)
  );

  serial_rx_classify u_classify (
    .shift_i   (shift),
    .mode8_i   (mode8_l),
    .par_en_i  (par_en_l),
    .par_odd_i (par_odd_l),
    .pbit_i    (pbit),
    .stop_i    (stop_b),
    .ent_o     (ent)
  );

  assign push = frame_done && !fifo_full;
  assign pop  = rd_i && !fifo_empty;

  serial_rx_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni,
    .push_i  (push),
    .din_i   (ent),
    .pop_i   (pop),
    .dout_o  (rd_data_o),
    .empty_o (fifo_empty),
    .full_o  (fifo_full),
    .cnt_o   (fifo_cnt)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                      overrun_o <= 1'b0;
    else if (frame_done && fifo_full) overrun_o <= 1'b1;
  end

  assign ready_o = !fifo_empty;
endmodule

// File: rtl/serial_rx_status_chk.sv
module serial_rx_status_chk #(
  parameter int DEPTH = 8,
  parameter int CW    = 4
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          rd_i,
  input logic          ready_o,
  input logic          overrun_o,
  input logic          frm_i,
  input logic          brk_i,
  input logic [7:0]    data_i,
  input logic          done_i,
  input logic [CW-1:0] cnt_i
);
  // R12
  overrun_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> overrun_o);
  // R12
  overrun_on_full_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_i && cnt_i == CW'(DEPTH)) |=> (overrun_o && cnt_i == $past(cnt_i) - CW'($past(rd_i))));
  // R7
  break_flags_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && brk_i) |-> (frm_i && data_i == 8'h00));
  // R10
  pop_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ready_o && rd_i && !done_i) |=> cnt_i == $past(cnt_i) - CW'(1));
  // R10
  idle_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ready_o && !done_i) |=> cnt_i == $past(cnt_i));
  // R9
  ready_level_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ready_o == (cnt_i != '0));
  // R11
  depth_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= CW'(DEPTH));
endmodule

bind serial_rx_status serial_rx_status_chk #(.DEPTH(FIFO_DEPTH), .CW(CW)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .rd_i      (rd_i),
  .ready_o   (ready_o),
  .overrun_o (overrun_o),
  .frm_i     (rd_data_o[10]),
  .brk_i     (rd_data_o[9]),
  .data_i    (rd_data_o[7:0]),
  .done_i    (frame_done),
  .cnt_i     (fifo_cnt)
);

// File: tb/serial_rx_status_tb_top.sv
module serial_rx_status_tb_top;
  localparam int BITC  = 32;  // 16 ticks, one tick every two clocks
  localparam int DEPTH = 8;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        tick_i = 1'b0;
  logic        rx_i = 1'b1;
  logic        mode8_i = 1'b1, par_en_i = 1'b0, par_odd_i = 1'b0, rd_i = 1'b0;
  logic [10:0] rd_data_o;
  logic        ready_o, overrun_o;

  int          vectors = 0, fails = 0, cycles = 0;
  bit          settled = 1'b0, pending_pop = 1'b0, model_ovf = 1'b0;
  string       cur_req = "R1";
  logic [10:0] model_q[$];

  serial_rx_status dut_i (.*);

  always #10 clk_i = ~clk_i;
  always @(negedge clk_i) tick_i <= ~tick_i;

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
  endtask

  always @(posedge clk_i) begin
    cycles++;
    if (cycles > 150000) begin
      fails++;
      $display("FAIL watchdog expired (actual hung, expected done)");
      summary();
      $finish;
    end
  end

  task automatic compare();
    bit exp_rdy;
    exp_rdy = (model_q.size() != 0);
    vectors++;
    if (ready_o !== exp_rdy || overrun_o !== model_ovf ||
        (exp_rdy && rd_data_o !== model_q[0])) begin
      fails++;
      $display("FAIL %s: actual rdy=%b ovf=%b word=%h expected rdy=%b ovf=%b word=%h",
               cur_req, ready_o, overrun_o, rd_data_o, exp_rdy, model_ovf,
               exp_rdy ? model_q[0] : 11'h0);
    end
  endtask

  task automatic cyc();
    @(negedge clk_i);
    if (pending_pop) begin
      if (model_q.size() != 0) void'(model_q.pop_front());
      pending_pop = 1'b0;
    end
    if (settled) compare();
  endtask

  function automatic logic [10:0] expect_word(logic [7:0] d, bit m8, bit pe, bit po,
                                               bit pbit, bit stopb);
    logic [7:0] dd;
    bit fe, brk, pe_err;
    dd     = m8 ? d : {1'b0, d[6:0]};
    fe     = !stopb;
    brk    = !stopb && dd == 8'h00;
    pe_err = pe && (po ? ((^dd ^ pbit) == 1'b0) : ((^dd ^ pbit) == 1'b1));
    if (brk && pe && po) pe_err = 1'b1;
    return {fe, brk, pe_err, dd};
  endfunction

  task automatic drive_bit(bit b);
    rx_i = b;
    repeat (BITC) cyc();
  endtask

  task automatic send_frame(logic [7:0] d, bit m8, bit pe, bit po, bit flip, bit stopb,
                            int extra_low);
    logic [7:0] dd;
    bit pbit;
    int nd;
    settled = 1'b0;
    mode8_i = m8; par_en_i = pe; par_odd_i = po;
    nd   = m8 ? 8 : 7;
    dd   = m8 ? d : {1'b0, d[6:0]};
    pbit = (po ? ~^dd : ^dd) ^ flip;
    drive_bit(1'b0);
    for (int i = 0; i < nd; i++) drive_bit(d[i]);
    if (pe) drive_bit(pbit);
    drive_bit(stopb);
    if (!stopb) repeat (extra_low) cyc();
    rx_i = 1'b1;
    repeat (2 * BITC) cyc();
    if (model_q.size() == DEPTH) model_ovf = 1'b1;
    else model_q.push_back(expect_word(d, m8, pe, po, pe ? pbit : 1'b0, stopb));
    settled = 1'b1;
    repeat (4) cyc();
  endtask

  task automatic do_read();
    rd_i = 1'b1;
    pending_pop = 1'b1;
    cyc();
    rd_i = 1'b0;
    repeat (3) cyc();
  endtask

  task automatic drain();
    while (model_q.size() != 0) do_read();
  endtask

  initial begin
    repeat (4) @(negedge clk_i);
    rst_ni = 1'b1;
    settled = 1'b1;
    cur_req = "R1";
    repeat (8) cyc();

    cur_req = "R10";  // read on empty queue is ignored
    do_read();

    cur_req = "R3";
    send_frame(8'hA5, 1, 0, 0, 0, 1, 0);
    send_frame(8'h01, 1, 0, 0, 0, 1, 0);
    drain();
    send_frame(8'h80, 1, 0, 0, 0, 1, 0);
    drain();

    cur_req = "R4";
    send_frame(8'hFF, 0, 0, 0, 0, 1, 0);
    send_frame(8'h55, 0, 0, 0, 0, 1, 0);
    drain();

    cur_req = "R5";
    send_frame(8'h3C, 1, 1, 0, 0, 1, 0);
    send_frame(8'h3D, 1, 1, 0, 1, 1, 0);
    send_frame(8'h3C, 1, 1, 1, 0, 1, 0);
    send_frame(8'h3D, 1, 1, 1, 1, 1, 0);
    send_frame(8'h7E, 0, 1, 1, 1, 1, 0);
    drain();

    cur_req = "R6";
    send_frame(8'h3C, 1, 0, 0, 0, 0, 0);
    drain();

    cur_req = "R7";
    send_frame(8'h00, 1, 0, 0, 0, 0, 0);
    send_frame(8'h00, 1, 1, 0, 0, 0, 0);
    drain();

    cur_req = "R8";
    send_frame(8'h00, 1, 1, 1, 1, 0, 0);
    send_frame(8'h00, 0, 1, 1, 0, 0, 0);
    drain();

    cur_req = "R13";
    send_frame(8'h00, 1, 0, 0, 0, 0, 3 * BITC);
    drain();

    cur_req = "R2";
    rx_i = 1'b0; repeat (4) cyc();
    rx_i = 1'b1; repeat (3 * BITC) cyc();
    rx_i = 1'b0; repeat (8) cyc();
    rx_i = 1'b1; repeat (3 * BITC) cyc();

    cur_req = "R11";
    for (int i = 0; i < DEPTH; i++)
      send_frame(8'(8'h11 * i), 1, 1, i[0], i[1], !(i == 5), 0);

    cur_req = "R12";
    send_frame(8'hEE, 1, 0, 0, 0, 1, 0);
    cur_req = "R9";
    drain();
    cur_req = "R12";
    send_frame(8'h42, 1, 0, 0, 0, 1, 0);
    drain();
    repeat (8) cyc();

    summary();
    $finish;
  end
endmodule